// File: doc/BRIEF.md
# TDM Multi-Microphone Bus Receiver

This block is the host-side master of a shared time-division bus that carries up to sixteen chained digital microphones. It divides the system clock down to a serial bit clock, issues a frame-start strobe, and gathers the bits that the microphones place one after another on a single data wire. For every time slot it hands out one 24-bit signed sample together with the slot's channel number and a one-cycle valid pulse.

A frame holds n slots of 32 bit clocks each, with n chosen from 2, 4, 8 or 16 by a two-bit setting. That setting is taken only when a frame begins. The device that sees the frame strobe first owns slot 0 and the next device in the chain owns slot 1. Each device launches its bits on a rising bit-clock edge. The receiver captures every bit on the rising edge that follows its launch. Bit positions that no device drives read as zero, because the line is pulled low.

Top module: `tdm_mic_rx`

## Requirements
- R1: A frame lasts n*32 bit-clock cycles, where n = 2 << cfg_chan (code 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16).
- R2: ws_out is high at exactly one rising edge of sck_out per frame, namely the edge that opens cycle 0, and it changes only in the system-clock cycle where sck_out falls.
- R3: sck_out is high for DIV_HALF system clocks and low for DIV_HALF system clocks.
- R4: Frame bit b is the value on sd_in during bit-clock cycle b+1, and it is captured at the rising edge that ends that cycle.
- R5: Slot k covers frame bits 32k to 32k+31 and gives the sample of channel k. Its first 24 bits are the word, most significant bit first.
- R6: smp_valid pulses for one system clock per slot, in the cycle after the rising edge that captures the slot's 24th bit. Channels arrive in the order 0 to n-1, and there are exactly n pulses per frame.
- R7: The 8 trailing bits of each slot have no effect on any output.
- R8: A slot that no device drives yields the word 0.
- R9: smp_ext equals smp_data sign-extended to 32 bits.
- R10: A change of cfg_chan in the middle of a frame leaves that frame's length and slot count unchanged. It takes effect from the next frame.
- R11: While rst is high, sck_out is 0, ws_out is 1 and smp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chan | input | 2 | Slot-count code; n = 2 << cfg_chan |
| sd_in | input | 1 | Shared serial data line |
| sck_out | output | 1 | Bit clock to the microphones |
| ws_out | output | 1 | Frame-start strobe to the first microphone |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_chan | output | 4 | Slot index of the sample |
| smp_data | output | 24 | Captured two's-complement word |
| smp_ext | output | 32 | Word sign-extended to 32 bits |

## Verification
A sample is due one system clock after the bit-clock rising edge that captures its 24th bit, which is 25 bit-clock cycles into its slot. The bench therefore samples smp_valid and the data outputs at the falling system-clock edge, half a period after that register updates. The frame-length and sample-count checks run at the rising bit-clock edge where the bench's microphone model sees ws_out high, because every sample of the frame has come out by then. The model applies a new channel count and a new microphone count at the same frame boundary where the design picks up cfg_chan, so each check compares against the frame the design is actually in.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    localparam int SLOT_BITS = 32;
    localparam int WORD_BITS = 24;
    localparam int MAX_CH    = 16;
    localparam int POS_W     = $clog2(MAX_CH * SLOT_BITS);
    localparam int CH_W      = $clog2(MAX_CH);
    localparam int SLOT_W    = $clog2(SLOT_BITS);

    typedef struct packed {
        logic [CH_W-1:0]      chan;
        logic [WORD_BITS-1:0] word;
    } sample_t;

    // last bit-clock index of a frame for a slot-count code
    function automatic logic [POS_W-1:0] last_pos(input logic [1:0] code);
        logic [POS_W:0] len;
        len = (POS_W+1)'(SLOT_BITS * 2) << code;
        return POS_W'(len - 1'b1);
    endfunction

    function automatic logic [SLOT_BITS-1:0] sign_ext(input logic [WORD_BITS-1:0] w);
        return {{(SLOT_BITS-WORD_BITS){w[WORD_BITS-1]}}, w};
    endfunction
endpackage

// File: rtl/tdm_clkgen.sv
module tdm_clkgen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    output logic sck,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(2 * DIV_HALF) : 1;

    logic [CNT_W-1:0] div_cnt;

    assign rise_tick = (div_cnt == CNT_W'(2 * DIV_HALF - 1));
    assign fall_tick = (div_cnt == CNT_W'(DIV_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= CNT_W'(DIV_HALF);
            sck     <= 1'b0;
        end else if (rise_tick) begin
            div_cnt <= '0;
            sck     <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            if (fall_tick)
                sck <= 1'b0;
        end
    end
endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
    import tdm_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic [1:0]       cfg_chan,
    output logic [POS_W-1:0] pos,
    output logic             ws
);
    logic [1:0]       n_code;
    logic [POS_W-1:0] end_pos;
    logic             at_end;

    assign end_pos = last_pos(n_code);
    assign at_end  = (pos >= end_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '1;
            n_code <= cfg_chan;
            ws     <= 1'b1;
        end else begin
            if (rise_tick) begin
                if (at_end) begin
                    pos    <= '0;
                    n_code <= cfg_chan;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
            if (fall_tick)
                ws <= at_end;
        end
    end
endmodule

// File: rtl/tdm_slot_capture.sv
module tdm_slot_capture
    import tdm_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_tick,
    input  logic [POS_W-1:0] pos,
    input  logic             sd_in,
    output logic             valid,
    output sample_t          sample
);
    logic [POS_W-1:0]     bit_idx;
    logic [SLOT_W-1:0]    bit_in_slot;
    logic [CH_W-1:0]      slot_idx;
    logic                 cap_en;
    logic [WORD_BITS-1:0] shreg;

    assign bit_idx     = pos - 1'b1;
    assign bit_in_slot = bit_idx[SLOT_W-1:0];
    assign slot_idx    = bit_idx[POS_W-1:SLOT_W];
    assign cap_en      = rise_tick && (pos != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            valid  <= 1'b0;
            sample <= '0;
        end else begin
            valid <= 1'b0;
            if (cap_en && bit_in_slot < SLOT_W'(WORD_BITS))
                shreg <= {shreg[WORD_BITS-2:0], sd_in};
            if (cap_en && bit_in_slot == SLOT_W'(WORD_BITS - 1)) begin
                valid       <= 1'b1;
                sample.chan <= slot_idx;
                sample.word <= {shreg[WORD_BITS-2:0], sd_in};
            end
        end
    end
endmodule

// File: rtl/tdm_mic_rx.sv
module tdm_mic_rx
    import tdm_rx_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_chan,
    input  logic                 sd_in,
    output logic                 sck_out,
    output logic                 ws_out,
    output logic                 smp_valid,
    output logic [CH_W-1:0]      smp_chan,
    output logic [WORD_BITS-1:0] smp_data,
    output logic [SLOT_BITS-1:0] smp_ext
);
    logic             rise_tick;
    logic             fall_tick;
    logic [POS_W-1:0] pos;
    sample_t          sample;

    tdm_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .sck       (sck_out),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    tdm_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .cfg_chan  (cfg_chan),
        .pos       (pos),
        .ws        (ws_out)
    );

    tdm_slot_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .rise_tick (rise_tick),
        .pos       (pos),
        .sd_in     (sd_in),
        .valid     (smp_valid),
        .sample    (sample)
    );

    assign smp_chan = sample.chan;
    assign smp_data = sample.word;
    assign smp_ext  = sign_ext(sample.word);
endmodule

// File: rtl/tdm_mic_rx_chk.sv
module tdm_mic_rx_chk
    import tdm_rx_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sck_out,
    input logic                 ws_out,
    input logic                 smp_valid,
    input logic [CH_W-1:0]      smp_chan,
    input logic [SLOT_BITS-1:0] smp_ext
);
    logic            prev_sck;
    int unsigned     run_len;
    logic [CH_W-1:0] last_chan;

    always_ff @(posedge clk) begin
        prev_sck <= sck_out;
        if (rst) begin
            run_len   <= 0;
            last_chan <= '0;
        end else begin
            run_len <= (sck_out != prev_sck) ? 1 : run_len + 1;
            if (smp_valid)
                last_chan <= smp_chan;
        end
    end

    // R3
    sck_half_period_chk: assert property (@(posedge clk) disable iff (rst)
        (sck_out != prev_sck) |-> (run_len == DIV_HALF));

    // R2
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws_out) |-> $fell(sck_out));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    // R6
    chan_order_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_chan != '0) |-> (smp_chan == CH_W'(last_chan + 1'b1)));

    // R9
    ext_sign_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> ($countones(smp_ext[SLOT_BITS-1:WORD_BITS-1]) == 0 ||
                       $countones(smp_ext[SLOT_BITS-1:WORD_BITS-1]) == SLOT_BITS - WORD_BITS + 1));
endmodule

bind tdm_mic_rx tdm_mic_rx_chk #(.DIV_HALF(DIV_HALF)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sck_out   (sck_out),
    .ws_out    (ws_out),
    .smp_valid (smp_valid),
    .smp_chan  (smp_chan),
    .smp_ext   (smp_ext)
);

// File: tb/tdm_mic_rx_tb.sv
module tdm_mic_rx_tb;
    localparam int DIV_HALF = 2;
    localparam int TCLK     = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_chan = 2'd0;
    logic        sd_in = 1'b0;
    logic        sck_out, ws_out, smp_valid;
    logic [3:0]  smp_chan;
    logic [23:0] smp_data;
    logic [31:0] smp_ext;

    always #(TCLK/2) clk = ~clk;

    tdm_mic_rx #(.DIV_HALF(DIV_HALF)) u_dut (
        .clk(clk), .rst(rst), .cfg_chan(cfg_chan), .sd_in(sd_in),
        .sck_out(sck_out), .ws_out(ws_out), .smp_valid(smp_valid),
        .smp_chan(smp_chan), .smp_data(smp_data), .smp_ext(smp_ext)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] pat(input int fr, input int k);
        case (fr % 3)
            0:       return k[0] ? 24'h800000 : 24'h7FFFFF;
            1:       return k[0] ? 24'hFFFFFF : 24'h000001;
            default: return 24'(fr * 40503 + k * 9973 + 24'h35A1C3);
        endcase
    endfunction

    // microphone chain model and frame bookkeeping
    int frame_no = -1;
    int cyc = 0;
    int cur_n = 2, cur_mics = 2, pend_n = 2, pend_mics = 2;
    int vcount = 0, exp_chan = 0;

    always @(posedge sck_out) begin : mic_model
        int b, slot, bi;
        logic [23:0] w;
        if (ws_out) begin
            if (frame_no >= 0) begin
                chk(cyc + 1 == cur_n * 32, "R1 R2 R10", "SCK cycles per frame", cyc + 1, cur_n * 32);
                chk(vcount == cur_n, "R6 R10", "samples per frame", vcount, cur_n);
            end
            frame_no++;
            cyc = 0;
            vcount = 0;
            exp_chan = 0;
            cur_n = pend_n;
            cur_mics = pend_mics;
        end else begin
            cyc++;
        end
        #1;
        if (frame_no >= 0 && cyc >= 1) begin
            b = cyc - 1;
            slot = b / 32;
            bi = b % 32;
            w = pat(frame_no, slot);
            if (slot < cur_mics)
                sd_in = (bi < 24) ? w[23 - bi] : 1'b1;  // trailing noise for R7
            else
                sd_in = 1'b0;                          // pulled low, R8
        end else begin
            sd_in = 1'b0;
        end
    end

    always @(negedge clk) begin : sample_check
        logic [23:0] ew;
        if (!rst && smp_valid) begin
            ew = (exp_chan < cur_mics) ? pat(frame_no, exp_chan) : 24'h0;
            chk(smp_chan == 4'(exp_chan), "R6", "channel index", smp_chan, exp_chan);
            if (exp_chan < cur_mics)
                chk(smp_data == ew, "R4 R5 R7", "sample word", smp_data, ew);
            else
                chk(smp_data == ew, "R8", "empty slot word", smp_data, ew);
            chk(smp_ext == 32'($signed(ew)), "R9", "sign-extended word", smp_ext, 32'($signed(ew)));
            vcount++;
            exp_chan++;
        end
    end

    initial begin : main
        time t0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(sck_out == 1'b0, "R11", "sck_out in reset", sck_out, 0);
        chk(ws_out == 1'b1, "R11", "ws_out in reset", ws_out, 1);
        chk(smp_valid == 1'b0, "R11", "smp_valid in reset", smp_valid, 0);
        rst = 1'b0;

        @(posedge sck_out);
        t0 = $time;
        @(posedge sck_out);
        chk(($time - t0) == 2 * DIV_HALF * TCLK, "R3", "SCK period", $time - t0, 2 * DIV_HALF * TCLK);

        for (int c = 0; c < 4; c++) begin
            for (int mm = 0; mm < 2; mm++) begin
                int n;
                n = 2 << c;
                @(posedge ws_out);
                repeat (20) @(posedge clk);
                @(negedge clk);
                // mid-frame change: R10 expects it from the next frame
                cfg_chan  = 2'(c);
                pend_n    = n;
                pend_mics = (mm == 0) ? n : n - 1;
                repeat (3) @(posedge ws_out);
            end
        end
        @(posedge sck_out);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule